// File: doc/BRIEF.md
# Collision-Avoidance Transmit Data State Machine

This block is the transmit data-path controller of a collision-avoidance reconciliation layer. It sits between the transmit MII signals of a MAC and the PHY's MII. When the collision-avoidance scheme is not in a good state, it behaves as a plain wire: MAC data, enable and carrier pass straight through. When the scheme is running, it decides when the MAC may send, based on a transmit-opportunity indication and a MAC-ready strobe. It pushes back on a MAC that starts too early by holding carrier or signalling a collision. Whenever it is not forwarding data, it drives encoded command symbols onto the PHY bus.

The control state machine that hands out opportunities and requests command symbols is outside this block. It appears here only as the inputs `txCmd`, `txOpp` and `statusOk`. All inputs are synchronous to the transmit clock. The command request is registered on every rising edge, and every symbol the block drives comes from that registered copy. This gives the PHY a stable symbol for the whole cycle.

Top module: `ca_tx_fsm`

## Requirements
- R1: Whenever `statusOk` is low at a rising edge, the next state is NORMAL. This overrides every other exit, including exits that would otherwise be taken unconditionally.
- R2: NORMAL forwards `macTxD` to `phyTxD` and `macTxEn` to `phyTxEn`. It holds `phyTxEr` at 0, drives `macCrs` equal to `crs` and keeps `macCol` at 0. It leaves to IDLE at the first edge where `statusOk` is high.
- R3: `txCmd` is captured on each rising edge. Command symbols reflect the captured value from the cycle after the edge. A change of `txCmd` between edges leaves the outputs unchanged.
- R4: Outside NORMAL and TRANSMIT, `phyTxEn` is 0 and the outputs carry the encoded symbol of the captured command. Code 2'b01 gives `phyTxD`=4'b0010 with `phyTxEr`=1. Code 2'b10 gives 4'b0011 with `phyTxEr`=1. Codes 2'b00 and 2'b11 give 4'b0000 with `phyTxEr`=0.
- R5: WAIT_MAC, PENDING, DELAY_PENDING, COLLIDE and ABORT each stay in place on any cycle where none of their exits holds.
- R6: WAIT_MAC goes to TRANSMIT only when `mcd` and `macTxEn` are both high. Otherwise it goes to IDLE when `txOpp` is low. `macCrs` is 0 in WAIT_MAC.
- R7: IDLE goes to WAIT_MAC when `txOpp` is high, and otherwise to HOLD when `macTxEn` is high. HOLD forces `macCrs` to 1. HOLD goes to ABORT when `macTxEn` falls, and otherwise to COLLIDE when `txOpp` is high.
- R8: COLLIDE drives `macCol`=1 and `macCrs`=1, and goes to DELAY_PENDING once `macTxEn` is low. DELAY_PENDING goes to PENDING when `crs` is low. PENDING goes to WAIT_MAC when `txOpp` is high. Both DELAY_PENDING and PENDING force `macCrs` to 1.
- R9: ABORT drives `macCrs` equal to `crs`, ignores `txOpp` and `macTxEn`, and returns to IDLE when `crs` is low.
- R10: TRANSMIT forwards `macTxD` and `macTxEn` with `phyTxEr`=0 and `macCrs`=1. It returns to IDLE when `macTxEn` is low.
- R11: A synchronous active-high `rst` places the machine in NORMAL. While `rst` is high, `phyTxEn` and `phyTxEr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| statusOk | input | 1 | Collision-avoidance scheme is in a good state |
| txCmd | input | 2 | Command symbol request from the control machine |
| txOpp | input | 1 | This node currently holds a transmit opportunity |
| mcd | input | 1 | MAC is ready to commit its frame |
| crs | input | 1 | Carrier sense from the PHY |
| macTxEn | input | 1 | MAC transmit enable |
| macTxD | input | 4 | MAC transmit nibble |
| phyTxD | output | 4 | Nibble to the PHY |
| phyTxEn | output | 1 | Transmit enable to the PHY |
| phyTxEr | output | 1 | Transmit error / command flag to the PHY |
| macCrs | output | 1 | Carrier sense presented to the MAC |
| macCol | output | 1 | Collision presented to the MAC |

## Verification
The bench aims at the global override while in COLLIDE and in WAIT_MAC with both TRANSMIT conditions true. A design that let the local exit win would still assert collision, or would raise MAC carrier on the following cycle. It sweeps every command code and changes `txCmd` between edges, which exposes a design that encodes the raw input instead of the captured copy. It tests each self-loop with an input that would move a neighbouring state, such as an opportunity arriving in ABORT. A machine that falls back to IDLE would then drop MAC carrier to 0 in WAIT_MAC. Every data nibble with both enable values is sent through NORMAL to catch a lane or enable mix-up.

// File: rtl/ca_tx_pkg.sv
package ca_tx_pkg;

  typedef enum logic [3:0] {
    ST_NORMAL,
    ST_IDLE,
    ST_WAIT_MAC,
    ST_TRANSMIT,
    ST_HOLD,
    ST_ABORT,
    ST_COLLIDE,
    ST_DELAY_PEND,
    ST_PENDING
  } txState_e;

  localparam logic [1:0] CMD_NONE   = 2'b00;
  localparam logic [1:0] CMD_BEACON = 2'b01;
  localparam logic [1:0] CMD_COMMIT = 2'b10;

  // Strobes from the control machine to the datapath
  typedef struct packed {
    logic passThru;  // forward MAC nibble and enable
    logic cmdOut;    // drive encoded command symbol
    logic crsHigh;   // force MAC carrier on
    logic crsLow;    // force MAC carrier off
    logic col;       // signal collision to MAC
  } dpCtl_t;

  // Low two bits of the command symbol nibble
  function automatic logic [1:0] cmdSym(input logic [1:0] code);
    case (code)
      CMD_BEACON: cmdSym = 2'b10;
      CMD_COMMIT: cmdSym = 2'b11;
      default:    cmdSym = 2'b00;
    endcase
  endfunction

  function automatic logic cmdErr(input logic [1:0] code);
    cmdErr = (code == CMD_BEACON) || (code == CMD_COMMIT);
  endfunction

endpackage

// File: rtl/ca_tx_ctrl.sv
module ca_tx_ctrl
  import ca_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     statusOk,
  input  logic     txOpp,
  input  logic     mcd,
  input  logic     crs,
  input  logic     macTxEn,
  output txState_e curState,
  output dpCtl_t   dpCtl
);

  txState_e nxtState;

  always_comb begin
    nxtState = curState;
    case (curState)
      ST_NORMAL:     if (statusOk) nxtState = ST_IDLE;
      ST_IDLE: begin
        if (txOpp)        nxtState = ST_WAIT_MAC;
        else if (macTxEn) nxtState = ST_HOLD;
      end
      ST_WAIT_MAC: begin
        if (mcd && macTxEn) nxtState = ST_TRANSMIT;
        else if (!txOpp)    nxtState = ST_IDLE;
      end
      ST_TRANSMIT:   if (!macTxEn) nxtState = ST_IDLE;
      ST_HOLD: begin
        if (!macTxEn)   nxtState = ST_ABORT;
        else if (txOpp) nxtState = ST_COLLIDE;
      end
      ST_ABORT:      if (!crs) nxtState = ST_IDLE;
      ST_COLLIDE:    if (!macTxEn) nxtState = ST_DELAY_PEND;
      ST_DELAY_PEND: if (!crs) nxtState = ST_PENDING;
      ST_PENDING:    if (txOpp) nxtState = ST_WAIT_MAC;
      default:       nxtState = ST_NORMAL;
    endcase
    // Global transition wins over every local exit
    if (!statusOk) nxtState = ST_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_NORMAL;
    else     curState <= nxtState;
  end

  always_comb begin
    dpCtl = '0;
    case (curState)
      ST_NORMAL:   dpCtl.passThru = 1'b1;
      ST_TRANSMIT: begin
        dpCtl.passThru = 1'b1;
        dpCtl.crsHigh  = 1'b1;
      end
      ST_WAIT_MAC: begin
        dpCtl.cmdOut = 1'b1;
        dpCtl.crsLow = 1'b1;
      end
      ST_HOLD, ST_DELAY_PEND, ST_PENDING: begin
        dpCtl.cmdOut  = 1'b1;
        dpCtl.crsHigh = 1'b1;
      end
      ST_COLLIDE: begin
        dpCtl.cmdOut  = 1'b1;
        dpCtl.crsHigh = 1'b1;
        dpCtl.col     = 1'b1;
      end
      default:     dpCtl.cmdOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/ca_tx_dp.sv
module ca_tx_dp
  import ca_tx_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            dpCtl,
  input  logic [1:0]        txCmd,
  input  logic              crs,
  input  logic              macTxEn,
  input  logic [DATA_W-1:0] macTxD,
  output logic [DATA_W-1:0] phyTxD,
  output logic              phyTxEn,
  output logic              phyTxEr,
  output logic              macCrs,
  output logic              macCol
);

  localparam int PAD_W = DATA_W - 2;

  logic [1:0] cmdSync;

  // Sample register: the symbol always comes from the last edge
  always_ff @(posedge clk) begin
    cmdSync <= txCmd;
  end

  always_comb begin
    phyTxD  = '0;
    phyTxEn = 1'b0;
    phyTxEr = 1'b0;
    if (!rst) begin
      if (dpCtl.passThru) begin
        phyTxD  = macTxD;
        phyTxEn = macTxEn;
      end else if (dpCtl.cmdOut) begin
        phyTxD  = {{PAD_W{1'b0}}, cmdSym(cmdSync)};
        phyTxEr = cmdErr(cmdSync);
      end
    end
  end

  always_comb begin
    if (dpCtl.crsHigh)     macCrs = 1'b1;
    else if (dpCtl.crsLow) macCrs = 1'b0;
    else                   macCrs = crs;
    macCol = dpCtl.col;
  end

endmodule

// File: rtl/ca_tx_fsm.sv
module ca_tx_fsm
  import ca_tx_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              statusOk,
  input  logic [1:0]        txCmd,
  input  logic              txOpp,
  input  logic              mcd,
  input  logic              crs,
  input  logic              macTxEn,
  input  logic [DATA_W-1:0] macTxD,
  output logic [DATA_W-1:0] phyTxD,
  output logic              phyTxEn,
  output logic              phyTxEr,
  output logic              macCrs,
  output logic              macCol
);

  txState_e curState;
  dpCtl_t   dpCtl;

  ca_tx_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .statusOk (statusOk),
    .txOpp    (txOpp),
    .mcd      (mcd),
    .crs      (crs),
    .macTxEn  (macTxEn),
    .curState (curState),
    .dpCtl    (dpCtl)
  );

  ca_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .dpCtl   (dpCtl),
    .txCmd   (txCmd),
    .crs     (crs),
    .macTxEn (macTxEn),
    .macTxD  (macTxD),
    .phyTxD  (phyTxD),
    .phyTxEn (phyTxEn),
    .phyTxEr (phyTxEr),
    .macCrs  (macCrs),
    .macCol  (macCol)
  );

endmodule

// File: rtl/ca_tx_fsm_chk.sv
module ca_tx_fsm_chk
  import ca_tx_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              statusOk,
  input logic [1:0]        txCmd,
  input logic              txOpp,
  input logic              mcd,
  input logic              macTxEn,
  input logic [DATA_W-1:0] macTxD,
  input logic [DATA_W-1:0] phyTxD,
  input logic              phyTxEn,
  input logic              phyTxEr,
  input logic              macCrs,
  input logic              macCol,
  input txState_e          curState
);

  p_global_normal_r1: assert property (@(posedge clk) disable iff (rst)
    !statusOk |=> curState == ST_NORMAL);

  p_normal_pass_r2: assert property (@(posedge clk) disable iff (rst)
    curState == ST_NORMAL |-> (phyTxD == macTxD && phyTxEn == macTxEn && !phyTxEr && !macCol));

  p_cmd_sampled_r3: assert property (@(posedge clk) disable iff (rst)
    (curState != ST_NORMAL && curState != ST_TRANSMIT)
      |-> (phyTxD[1:0] == cmdSym($past(txCmd)) && phyTxEr == cmdErr($past(txCmd)) && !phyTxEn));

  p_pend_stay_r5: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_PENDING && !txOpp && statusOk) |=> curState == ST_PENDING);

  p_wait_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_WAIT_MAC && !(mcd && macTxEn)) |=> curState != ST_TRANSMIT);

  p_hold_crs_r7: assert property (@(posedge clk) disable iff (rst)
    curState == ST_HOLD |-> macCrs);

  p_col_entry_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(macCol) |-> $past(curState) == ST_HOLD);

  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |-> (!phyTxEn && !phyTxEr));

endmodule

bind ca_tx_fsm ca_tx_fsm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .statusOk (statusOk),
  .txCmd    (txCmd),
  .txOpp    (txOpp),
  .mcd      (mcd),
  .macTxEn  (macTxEn),
  .macTxD   (macTxD),
  .phyTxD   (phyTxD),
  .phyTxEn  (phyTxEn),
  .phyTxEr  (phyTxEr),
  .macCrs   (macCrs),
  .macCol   (macCol),
  .curState (curState)
);

// File: tb/ca_tx_fsm_tb_top.sv
module ca_tx_fsm_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       statusOk = 1'b0;
  logic [1:0] txCmd = 2'b00;
  logic       txOpp = 1'b0;
  logic       mcd = 1'b0;
  logic       crs = 1'b0;
  logic       macTxEn = 1'b0;
  logic [3:0] macTxD = 4'd0;
  logic [3:0] phyTxD;
  logic       phyTxEn, phyTxEr, macCrs, macCol;

  int checks = 0;
  int errors = 0;
  int prevCmd;

  always #10 clk = ~clk;

  ca_tx_fsm dut_i (
    .clk(clk), .rst(rst), .statusOk(statusOk), .txCmd(txCmd), .txOpp(txOpp),
    .mcd(mcd), .crs(crs), .macTxEn(macTxEn), .macTxD(macTxD),
    .phyTxD(phyTxD), .phyTxEn(phyTxEn), .phyTxEr(phyTxEr),
    .macCrs(macCrs), .macCol(macCol)
  );

  function automatic int expD(input int c);
    return (c == 1) ? 2 : (c == 2) ? 3 : 0;
  endfunction

  function automatic int expE(input int c);
    return (c == 1 || c == 2) ? 1 : 0;
  endfunction

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11: reset quiet
    macTxEn = 1'b1; macTxD = 4'd5;
    tick(); tick(); tick();
    chk("R11 txEn in reset", phyTxEn, 0);
    chk("R11 txEr in reset", phyTxEr, 0);
    rst = 1'b0; macTxEn = 1'b0;
    tick();

    // R2: NORMAL passes every nibble and enable
    for (int d = 0; d < 16; d++) begin
      for (int en = 0; en < 2; en++) begin
        macTxD = d[3:0]; macTxEn = en[0]; crs = d[0];
        #1;
        chk("R2 txd", phyTxD, d);
        chk("R2 txen", phyTxEn, en);
        chk("R2 crs", macCrs, d & 1);
        chk("R2 er/col", {phyTxEr, macCol}, 0);
      end
    end
    // R1: stays in NORMAL while status bad
    macTxEn = 1'b1; macTxD = 4'd7; txCmd = 2'd1; crs = 1'b0;
    tick(); tick();
    chk("R1 sticky normal txen", phyTxEn, 1);
    chk("R1 sticky normal er", phyTxEr, 0);

    // R2 exit to IDLE
    macTxEn = 1'b0; statusOk = 1'b1;
    tick();
    chk("R2 exit idle txd", phyTxD, expD(1));
    prevCmd = 1;

    // R3/R4: every command code, raw change between edges ignored
    for (int c = 0; c < 4; c++) begin
      txCmd = c[1:0];
      #1;
      chk("R3 raw ignored", phyTxD, expD(prevCmd));
      tick();
      chk("R4 txd", phyTxD, expD(c));
      chk("R4 txer", phyTxEr, expE(c));
      chk("R4 txen", phyTxEn, 0);
      prevCmd = c;
    end
    txCmd = 2'd2;
    tick();

    // R6: WAIT_MAC gating
    txOpp = 1'b1; crs = 1'b1;
    tick();
    chk("R6 wait crs low", macCrs, 0);
    macTxEn = 1'b1; mcd = 1'b0; macTxD = 4'd9;
    tick();
    chk("R6 no tx without mcd", phyTxEn, 0);
    tick();
    chk("R5 wait stays", macCrs, 0);
    mcd = 1'b1;
    tick();
    chk("R10 tx en", phyTxEn, 1);
    chk("R10 tx data", phyTxD, 9);
    chk("R10 tx crs", macCrs, 1);
    chk("R10 tx er", phyTxEr, 0);
    macTxD = 4'd4; #1;
    chk("R10 tx data follows", phyTxD, 4);
    macTxEn = 1'b0; txOpp = 1'b0; mcd = 1'b0;
    tick();
    chk("R10 back to idle er", phyTxEr, 1);
    chk("R10 back to idle txd", phyTxD, 3);

    // R6: WAIT_MAC leaves when opportunity drops
    txOpp = 1'b1; tick();
    chk("R7 idle to wait", macCrs, 0);
    txOpp = 1'b0; tick();
    chk("R6 wait to idle", macCrs, 1);

    // R7/R8: HOLD, COLLIDE, DELAY_PENDING, PENDING
    crs = 1'b0; macTxEn = 1'b1;
    tick();
    chk("R7 hold crs", macCrs, 1);
    chk("R7 hold txen", phyTxEn, 0);
    chk("R7 hold txd", phyTxD, 3);
    txOpp = 1'b1;
    tick();
    chk("R8 collide col", macCol, 1);
    tick();
    chk("R5 collide stays", macCol, 1);
    macTxEn = 1'b0; txOpp = 1'b0; crs = 1'b1;
    tick();
    chk("R8 delay col", macCol, 0);
    chk("R8 delay crs", macCrs, 1);
    tick();
    chk("R5 delay stays", macCrs, 1);
    crs = 1'b0;
    tick();
    chk("R8 pending crs", macCrs, 1);
    tick();
    chk("R5 pending stays", macCrs, 1);
    txOpp = 1'b1;
    tick();
    chk("R8 pending to wait", macCrs, 0);
    txOpp = 1'b0;
    tick();

    // R9: ABORT
    macTxEn = 1'b1; tick();
    macTxEn = 1'b0; crs = 1'b1; tick();
    chk("R9 abort crs", macCrs, 1);
    txOpp = 1'b1; macTxEn = 1'b1; tick();
    chk("R9 abort ignores opp", macCrs, 1);
    crs = 1'b0; #1;
    chk("R9 abort crs follows", macCrs, 0);
    txOpp = 1'b0; macTxEn = 1'b0; tick();
    macTxEn = 1'b1; tick();
    chk("R9 abort to idle then hold", macCrs, 1);

    // R1: override from COLLIDE
    txOpp = 1'b1; tick();
    chk("R1 pre collide", macCol, 1);
    statusOk = 1'b0; macTxD = 4'd11; tick();
    chk("R1 collide override col", macCol, 0);
    chk("R1 collide override txen", phyTxEn, 1);
    chk("R1 collide override txd", phyTxD, 11);

    // R1: override over WAIT_MAC to TRANSMIT
    statusOk = 1'b1; macTxEn = 1'b0; txOpp = 1'b0; tick();
    txOpp = 1'b1; tick();
    mcd = 1'b1; macTxEn = 1'b1; statusOk = 1'b0; crs = 1'b0; tick();
    chk("R1 wait override crs", macCrs, 0);

    // R11: reset mid-run
    rst = 1'b1; tick();
    chk("R11 mid reset txen", phyTxEn, 0);
    chk("R11 mid reset txer", phyTxEr, 0);
    rst = 1'b0; #1;
    chk("R11 normal after reset", phyTxEn, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule